// File: doc/BRIEF.md
# Video RAM Copy Engine with General and Per-HBlank Modes

This block moves bytes from anywhere in the address map into video RAM under control of a single control write. The four address bytes live in neighbouring registers outside the block and are presented to it continuously. A write to the control register either launches a one-shot copy whose length is a whole number of 16-byte blocks, or arms a paced mode in which one 16-byte block is copied each time the display enters horizontal blanking.

Each byte takes two cycles. In the first cycle the block issues a read. In the second cycle it writes the returned byte into video RAM. The processor stall output stays high for the whole block. When a block ends, the block emits a one-cycle strobe carrying the advanced source and destination addresses, so that the outside registers can be updated. A control readback value reports progress: the remaining block count, completion, or a rejected request.

Top module: `vram_dma_ctrl`

## Requirements
- R1: After reset the stall, read enable, write enable and writeback strobe are low, and the control readback is 0xFF.
- R2: The source is the 16-bit source register pair with its low four bits cleared. The destination is the destination pair with bits 15..13 and 3..0 cleared and then bit 15 set. Byte n of a block is read from source+n and written to destination+n.
- R3: If the cleared source lies in 0x8000..0x9FFF, the control write starts nothing. The readback becomes the written value with bit 7 set.
- R4: A control write with bit 7 clear, while the per-HBlank mode is idle, copies ((value & 0x7F) + 1) × 16 bytes at once. The readback is value & 0x7F during the copy and 0xFF after it.
- R5: Every byte reads in one cycle and writes the data returned by the memory one cycle later, in the next cycle. Stall is high for exactly 2 cycles per byte, starting the cycle after the accepting edge.
- R6: A control write with bit 7 set while the video mode input is 0 copies one 16-byte block at once. The readback is value & 0x7F and drops by one when the block ends.
- R7: A control write with bit 7 set while the video mode is nonzero and the LCD is on reads back value & 0x7F and copies nothing. Each later HBlank-entry pulse copies one 16-byte block.
- R8: A control write with bit 7 set while the video mode is nonzero and the LCD is off reads back 0x80 | ((value + 1) & 0x7F).
- R9: In the last write cycle of each block the writeback strobe presents the source and destination one past the last byte. Stall falls in the next cycle.
- R10: In the per-HBlank mode the readback decrements after every block. When it wraps to 0xFF the mode ends, and further pulses copy nothing.
- R11: Control writes and HBlank-entry pulses that arrive while stall is high are ignored. This includes a pulse in the final write cycle of a block.
- R12: A control write with bit 7 clear while the per-HBlank mode is armed and the video mode is nonzero disarms the mode, copies nothing, and reads back value & 0x7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_hi_i | input | 8 | Source address high byte register |
| src_lo_i | input | 8 | Source address low byte register |
| dst_hi_i | input | 8 | Destination address high byte register |
| dst_lo_i | input | 8 | Destination address low byte register |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data; bit 7 selects per-HBlank mode |
| vid_mode_i | input | 2 | Current video mode, 0 meaning horizontal blanking |
| lcd_on_i | input | 1 | LCD enabled |
| hblank_pulse_i | input | 1 | One-cycle pulse on entry into horizontal blanking |
| rd_en_o | output | 1 | Byte read request |
| rd_addr_o | output | 16 | Byte read address |
| rd_data_i | input | 8 | Read data, valid the cycle after rd_en_o |
| wr_en_o | output | 1 | Video RAM byte write enable |
| wr_addr_o | output | 16 | Video RAM byte write address |
| wr_data_o | output | 8 | Video RAM byte write data |
| stall_o | output | 1 | Processor stall while a block is copied |
| ctl_rdata_o | output | 8 | Control register readback |
| wb_en_o | output | 1 | Address writeback strobe at block end |
| wb_src_o | output | 16 | Source address to store back |
| wb_dst_o | output | 16 | Destination address to store back |

## Verification
The final write cycle of a block, which carries the writeback and the count update, can share a cycle with an HBlank-entry pulse. The bench waits for the writeback strobe at a falling edge and raises the pulse in that same cycle. The pulse must be lost: the bench then expects no further writes for many cycles, a readback decremented exactly once, and a normal block only on the next pulse. A control write placed in the middle of a copy is judged the same way, by an unchanged write stream and a final readback of 0xFF.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
    localparam int unsigned ADDR_W    = 16;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned BLK_BYTES = 16;
    localparam int unsigned BLK_SH    = $clog2(BLK_BYTES);
    localparam int unsigned CNT_W     = 7;
    localparam int unsigned MODE_BIT  = 7;
    localparam int unsigned LEN_W     = CNT_W + BLK_SH + 1;

    localparam logic [ADDR_W-1:0] VRAM_BASE = 16'h8000;
    localparam logic [ADDR_W-1:0] VRAM_SPAN = 16'h2000;
    localparam logic [ADDR_W-1:0] BLK_MASK  = ~ADDR_W'(BLK_BYTES - 1);
    localparam logic [ADDR_W-1:0] DST_MASK  = (VRAM_SPAN - 16'd1) & BLK_MASK;

    typedef struct packed {
        logic              valid;
        logic              go;
        logic              hb;
        logic [DATA_W-1:0] rdback;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
    } ctl_dec_t;

    typedef struct packed {
        logic              busy;
        logic              phase;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [LEN_W-1:0]  left;
    } mover_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] ctl;
        logic              armed;
    } ctl_state_t;
endpackage

// File: rtl/vdma_ctl_decode.sv
module vdma_ctl_decode
    import vdma_pkg::*;
(
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [7:0]        src_hi_i,
    input  logic [7:0]        src_lo_i,
    input  logic [7:0]        dst_hi_i,
    input  logic [7:0]        dst_lo_i,
    input  logic              hb_armed_i,
    input  logic [1:0]        vid_mode_i,
    input  logic              lcd_on_i,
    output ctl_dec_t          dec_o
);
    logic [CNT_W:0]      nblk;
    logic [ADDR_W-1:0]   src_m;
    logic [ADDR_W-1:0]   dst_m;
    logic                want_hb;

    always_comb begin
        want_hb = wdata_i[MODE_BIT];
        src_m   = {src_hi_i, src_lo_i} & BLK_MASK;
        dst_m   = ({dst_hi_i, dst_lo_i} & DST_MASK) | VRAM_BASE;
        nblk    = {1'b0, wdata_i[CNT_W-1:0]} + {{CNT_W{1'b0}}, 1'b1};

        dec_o.src   = src_m;
        dec_o.dst   = dst_m;
        dec_o.hb    = want_hb;
        dec_o.valid = !((src_m >= VRAM_BASE) && (src_m < VRAM_BASE + VRAM_SPAN));
        dec_o.len   = want_hb ? LEN_W'(BLK_BYTES) : (LEN_W'(nblk) << BLK_SH);
        dec_o.go    = dec_o.valid &&
                      ((!hb_armed_i && !want_hb) || (vid_mode_i == 2'd0));

        if (!dec_o.valid)
            dec_o.rdback = wdata_i | 8'h80;
        else if (!dec_o.go && want_hb && !lcd_on_i)
            dec_o.rdback = {1'b1, wdata_i[CNT_W-1:0] + 7'd1};
        else
            dec_o.rdback = {1'b0, wdata_i[CNT_W-1:0]};
    end
endmodule

// File: rtl/vdma_mover.sv
module vdma_mover
    import vdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] end_src_o,
    output logic [ADDR_W-1:0] end_dst_o
);
    mover_state_t s_d, s_q;
    logic         last_byte;

    always_comb begin
        s_d       = s_q;
        last_byte = (s_q.left == LEN_W'(1));
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.busy  = 1'b1;
                s_d.phase = 1'b0;
                s_d.src   = src_i;
                s_d.dst   = dst_i;
                s_d.left  = len_i;
            end
        end else if (!s_q.phase) begin
            s_d.phase = 1'b1;
        end else begin
            s_d.phase = 1'b0;
            s_d.src   = s_q.src + 16'd1;
            s_d.dst   = s_q.dst + 16'd1;
            s_d.left  = s_q.left - LEN_W'(1);
            if (last_byte)
                s_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign busy_o    = s_q.busy;
    assign rd_en_o   = s_q.busy && !s_q.phase;
    assign rd_addr_o = s_q.src;
    assign wr_en_o   = s_q.busy && s_q.phase;
    assign wr_addr_o = s_q.dst;
    assign wr_data_o = rd_data_i;
    assign done_o    = s_q.busy && s_q.phase && last_byte;
    assign end_src_o = s_q.src + 16'd1;
    assign end_dst_o = s_q.dst + 16'd1;
endmodule

// File: rtl/vram_dma_ctrl.sv
module vram_dma_ctrl
    import vdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  src_hi_i,
    input  logic [7:0]  src_lo_i,
    input  logic [7:0]  dst_hi_i,
    input  logic [7:0]  dst_lo_i,
    input  logic        ctl_we_i,
    input  logic [7:0]  ctl_wdata_i,
    input  logic [1:0]  vid_mode_i,
    input  logic        lcd_on_i,
    input  logic        hblank_pulse_i,
    output logic        rd_en_o,
    output logic [15:0] rd_addr_o,
    input  logic [7:0]  rd_data_i,
    output logic        wr_en_o,
    output logic [15:0] wr_addr_o,
    output logic [7:0]  wr_data_o,
    output logic        stall_o,
    output logic [7:0]  ctl_rdata_o,
    output logic        wb_en_o,
    output logic [15:0] wb_src_o,
    output logic [15:0] wb_dst_o
);
    ctl_state_t          t_d, t_q;
    ctl_dec_t            dec;
    logic                busy;
    logic                blk_done;
    logic                accept;
    logic                pulse_go;
    logic                start;
    logic [ADDR_W-1:0]   start_src;
    logic [ADDR_W-1:0]   start_dst;
    logic [LEN_W-1:0]    start_len;

    vdma_ctl_decode u_dec (
        .wdata_i    (ctl_wdata_i),
        .src_hi_i   (src_hi_i),
        .src_lo_i   (src_lo_i),
        .dst_hi_i   (dst_hi_i),
        .dst_lo_i   (dst_lo_i),
        .hb_armed_i (t_q.armed),
        .vid_mode_i (vid_mode_i),
        .lcd_on_i   (lcd_on_i),
        .dec_o      (dec)
    );

    always_comb begin
        accept    = ctl_we_i && !busy;
        pulse_go  = hblank_pulse_i && !busy && !ctl_we_i && t_q.armed;
        start     = (accept && dec.go) || pulse_go;
        start_src = dec.src;
        start_dst = dec.dst;
        start_len = accept ? dec.len : LEN_W'(BLK_BYTES);

        t_d = t_q;
        if (accept) begin
            t_d.ctl = dec.rdback;
            if (dec.valid)
                t_d.armed = dec.hb;
        end else if (blk_done) begin
            if (t_q.armed) begin
                t_d.ctl = t_q.ctl - 8'd1;
                if (t_q.ctl == 8'h00)
                    t_d.armed = 1'b0;
            end else begin
                t_d.ctl = 8'hFF;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.ctl   <= 8'hFF;
            t_q.armed <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    vdma_mover u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .src_i     (start_src),
        .dst_i     (start_dst),
        .len_i     (start_len),
        .rd_data_i (rd_data_i),
        .busy_o    (busy),
        .rd_en_o   (rd_en_o),
        .rd_addr_o (rd_addr_o),
        .wr_en_o   (wr_en_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o),
        .done_o    (blk_done),
        .end_src_o (wb_src_o),
        .end_dst_o (wb_dst_o)
    );

    assign stall_o     = busy;
    assign ctl_rdata_o = t_q.ctl;
    assign wb_en_o     = blk_done;
endmodule

// File: rtl/vram_dma_ctrl_chk.sv
module vram_dma_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_we_i,
    input logic        rd_en_o,
    input logic [15:0] rd_addr_o,
    input logic        wr_en_o,
    input logic [15:0] wr_addr_o,
    input logic        stall_o,
    input logic [7:0]  ctl_rdata_o,
    input logic        wb_en_o,
    input logic [15:0] wb_dst_o
);
    assert_rw_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_o && wr_en_o));

    assert_write_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(rd_en_o));

    assert_src_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && $past(wr_en_o)) |-> (rd_addr_o == $past(rd_addr_o) + 16'd1));

    assert_wb_last_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> (wr_en_o && (wb_dst_o == wr_addr_o + 16'd1)));

    assert_stall_falls_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |=> !stall_o);

    assert_busy_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we_i && stall_o && !wb_en_o) |=> $stable(ctl_rdata_o));
endmodule

bind vram_dma_ctrl vram_dma_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_we_i    (ctl_we_i),
    .rd_en_o     (rd_en_o),
    .rd_addr_o   (rd_addr_o),
    .wr_en_o     (wr_en_o),
    .wr_addr_o   (wr_addr_o),
    .stall_o     (stall_o),
    .ctl_rdata_o (ctl_rdata_o),
    .wb_en_o     (wb_en_o),
    .wb_dst_o    (wb_dst_o)
);

// File: tb/tb_vram_dma_ctrl.sv
module tb_vram_dma_ctrl;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [7:0]  src_hi = 8'h00, src_lo = 8'h00, dst_hi = 8'h00, dst_lo = 8'h00;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wdata = 8'h00;
    logic [1:0]  vid_mode = 2'd3;
    logic        lcd_on = 1'b1;
    logic        hb_pulse = 1'b0;
    logic        rd_en, wr_en, stall, wb_en;
    logic [15:0] rd_addr, wr_addr, wb_src, wb_dst;
    logic [7:0]  rd_data = 8'h00;
    logic [7:0]  wr_data, ctl_rdata;
    logic        ld = 1'b0;
    logic [15:0] ld_src = 16'h0, ld_dst = 16'h0;

    int checks = 0;
    int fails  = 0;
    logic [23:0] wq[$];
    logic [31:0] bq[$];

    vram_dma_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .src_hi_i(src_hi), .src_lo_i(src_lo), .dst_hi_i(dst_hi), .dst_lo_i(dst_lo),
        .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
        .vid_mode_i(vid_mode), .lcd_on_i(lcd_on), .hblank_pulse_i(hb_pulse),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .stall_o(stall), .ctl_rdata_o(ctl_rdata),
        .wb_en_o(wb_en), .wb_src_o(wb_src), .wb_dst_o(wb_dst)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // memory with one-cycle read latency and the outside address registers
    always @(posedge clk) begin
        if (rd_en) rd_data <= pat(rd_addr);
        if (wb_en) {src_hi, src_lo, dst_hi, dst_lo} <= {wb_src, wb_dst};
        else if (ld) {src_hi, src_lo, dst_hi, dst_lo} <= {ld_src, ld_dst};
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                if (wq.size() == 0) chk("R11 unexpected write", {16'h0, wr_addr}, 32'hFFFFFFFF);
                else chk("R2 R5 write addr/data", {8'h0, wr_addr, wr_data}, {8'h0, wq.pop_front()});
            end
            if (wb_en) begin
                if (bq.size() == 0) chk("R9 unexpected writeback", {wb_src, wb_dst}, 32'hFFFFFFFF);
                else chk("R9 writeback", {wb_src, wb_dst}, bq.pop_front());
            end
        end
    end

    task automatic exp_block(input logic [15:0] s, input logic [15:0] d, input int n);
        for (int i = 0; i < n; i++) wq.push_back({d + 16'(i), pat(s + 16'(i))});
        bq.push_back({s + 16'(n), d + 16'(n)});
    endtask

    task automatic set_regs(input logic [15:0] s, input logic [15:0] d);
        @(posedge clk); #2 ld = 1'b1; ld_src = s; ld_dst = d;
        @(posedge clk); #2 ld = 1'b0;
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(posedge clk); #2 ctl_we = 1'b1; ctl_wdata = v;
        @(posedge clk); #2 ctl_we = 1'b0;
    endtask

    task automatic pulse();
        @(posedge clk); #2 hb_pulse = 1'b1;
        @(posedge clk); #2 hb_pulse = 1'b0;
    endtask

    task automatic wait_idle(output int cnt);
        cnt = 0;
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk);
            if (!stall) break;
            cnt++;
        end
        chk("R5 all expected writes seen", wq.size(), 0);
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset stall", stall, 0);
        chk("R1 reset rd/wr", {rd_en, wr_en, wb_en}, 0);
        chk("R1 reset readback", ctl_rdata, 8'hFF);

        // R2 R4: single general block with masked addresses
        set_regs(16'h1234, 16'hFF3F);
        exp_block(16'h1230, 16'h9F30, 16);
        wr_ctl(8'h00);
        chk("R4 readback during copy", ctl_rdata, 8'h00);
        wait_idle(cnt);
        chk("R5 stall cycles 16 bytes", cnt, 32);
        chk("R4 readback done", ctl_rdata, 8'hFF);

        // R4 R5 R9: three blocks continuing from written-back registers
        exp_block(16'h1240, 16'h9F40, 48);
        wr_ctl(8'h02);
        chk("R4 readback during copy", ctl_rdata, 8'h02);
        wait_idle(cnt);
        chk("R5 stall cycles 48 bytes", cnt, 96);
        chk("R4 readback done", ctl_rdata, 8'hFF);
        chk("R9 registers updated", {src_hi, src_lo, dst_hi, dst_lo}, 32'h12709F70);

        // R3: rejected sources
        set_regs(16'h8800, 16'h0000);
        wr_ctl(8'h05);
        chk("R3 readback", ctl_rdata, 8'h85);
        idle_cycles(10);
        chk("R3 no stall", stall, 0);
        set_regs(16'h9FFF, 16'h0000);
        wr_ctl(8'h00);
        chk("R3 top of window", ctl_rdata, 8'h80);
        idle_cycles(10);
        chk("R3 no stall", stall, 0);
        set_regs(16'h7FFF, 16'h0000);
        exp_block(16'h7FF0, 16'h8000, 16);
        wr_ctl(8'h00);
        chk("R3 just below window accepted", ctl_rdata, 8'h00);
        wait_idle(cnt);
        chk("R4 readback done", ctl_rdata, 8'hFF);

        // R6 R10: per-HBlank start during blanking
        vid_mode = 2'd0;
        set_regs(16'hC000, 16'h0100);
        exp_block(16'hC000, 16'h8100, 16);
        wr_ctl(8'h81);
        chk("R6 readback", ctl_rdata, 8'h01);
        wait_idle(cnt);
        chk("R6 one block", cnt, 32);
        chk("R6 decremented", ctl_rdata, 8'h00);
        vid_mode = 2'd3;
        exp_block(16'hC010, 16'h8110, 16);
        pulse();
        wait_idle(cnt);
        chk("R10 wrapped", ctl_rdata, 8'hFF);
        pulse();
        idle_cycles(40);
        chk("R10 no copy after end", stall, 0);

        // R7 R11: armed waiting, pulse at final write cycle
        vid_mode = 2'd2;
        set_regs(16'h4000, 16'h0200);
        wr_ctl(8'h81);
        chk("R7 readback", ctl_rdata, 8'h01);
        idle_cycles(10);
        chk("R7 waits for pulse", stall, 0);
        exp_block(16'h4000, 16'h8200, 16);
        pulse();
        for (int g = 0; g < 200; g++) begin
            @(negedge clk);
            if (wb_en) break;
        end
        hb_pulse = 1'b1;
        @(posedge clk); #2 hb_pulse = 1'b0;
        idle_cycles(40);
        chk("R11 coincident pulse ignored", stall, 0);
        chk("R11 single decrement", ctl_rdata, 8'h00);
        exp_block(16'h4010, 16'h8210, 16);
        pulse();
        idle_cycles(5);
        wr_ctl(8'h05);
        wait_idle(cnt);
        chk("R11 write during copy ignored", ctl_rdata, 8'hFF);
        idle_cycles(20);
        chk("R11 no late copy", stall, 0);

        // R8 R12: LCD off readback, then disarm
        vid_mode = 2'd3;
        lcd_on = 1'b0;
        set_regs(16'h2000, 16'h0000);
        wr_ctl(8'h85);
        chk("R8 readback", ctl_rdata, 8'h86);
        wr_ctl(8'hFF);
        chk("R8 count wraps", ctl_rdata, 8'h80);
        lcd_on = 1'b1;
        wr_ctl(8'h03);
        chk("R12 readback", ctl_rdata, 8'h03);
        idle_cycles(5);
        chk("R12 no copy", stall, 0);
        pulse();
        idle_cycles(40);
        chk("R12 disarmed", stall, 0);

        summary();
        $finish;
    end
endmodule